// File: doc/BRIEF.md
# Dual-Port Byte Memory with Collision Arbiter

This block is a clocked model of a byte-wide memory that two independent agents, called left and right, can reach at once. Each side has its own address, write data, read data, a write strobe (low means write), an output enable (low means drive read data), and a select pair made of one active-low and one active-high enable. Read data appears one clock after the request, together with a valid flag. The valid flag stands in for a high-impedance pad: it is low whenever the side is not reading.

When both sides are selected on the same location and at least one of them writes, an arbiter picks a winner. It signals busy to the loser, and the loser's write is dropped. A strap input picks the cascade role. In the primary role the block computes both busy flags and drives them out. In the secondary role it takes both busy flags from outside, so several instances can share one arbiter and form a wider word.

Top module: `dpram_arb`

## Requirements
- R1: A side is selected only when its active-low enable is 0 and its active-high enable is 1. The other three combinations neither write nor read.
- R2: A selected side with the write strobe at 0 stores its write data at its address at the clock edge, whatever its output enable is.
- R3: A selected side with the write strobe at 1 and the output enable at 0 presents the stored byte on its read data one clock later, with its valid flag at 1.
- R4: In the cycle after a request that is not a selected read (output enable at 1, deselected, or a write), the valid flag of that side is 0.
- R5: Both sides may read the same address in the same cycle. Neither busy flag rises, and both return the stored byte.
- R6: A collision exists only when both sides are selected, their addresses are equal, and at least one of them is writing. In the primary role exactly one busy flag is 1 during a collision, and both are 0 otherwise.
- R7: In a collision where neither side held the address in the previous cycle, or both held it, the left side wins and right busy is 1.
- R8: A side that was selected on the same address in the previous cycle holds the location. If only the right side holds it, the right side wins and left busy is 1.
- R9: A side whose effective busy is 1 has its write suppressed, so the location keeps its earlier contents.
- R10: With the strap at 0 (secondary role), both busy outputs are 0. Each busy input blocks the writes of its side.
- R11: With the strap at 1 (primary role), the busy inputs have no effect.
- R12: After reset, both valid flags and both busy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | Cascade role strap: 1 primary, 0 secondary |
| l_cs_n | input | 1 | Left active-low enable |
| l_cs | input | 1 | Left active-high enable |
| l_rw_n | input | 1 | Left strobe: 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_in | input | 1 | Left busy from outside (secondary role) |
| l_busy_out | output | 1 | Left busy from arbiter (primary role) |
| r_cs_n | input | 1 | Right active-low enable |
| r_cs | input | 1 | Right active-high enable |
| r_rw_n | input | 1 | Right strobe: 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_in | input | 1 | Right busy from outside (secondary role) |
| r_busy_out | output | 1 | Right busy from arbiter (primary role) |

## Verification
The bench builds the block with a 4-bit address and 8-bit data, giving 16 locations. That is small enough to fill and read back every location from each side. It is also small enough to run every pairing of left write address against right read address, so the busy flag is checked at all 256 combinations of equal and unequal addresses. The same setting covers all four enable combinations, the tie and hold cases of the arbiter, and both strap roles.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
    } port_req_t;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_L    = 0;
    localparam int SIDE_R    = 1;
endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec
    import dpram_pkg::*;
(
    input  logic      cs_n,
    input  logic      cs,
    input  logic      rw_n,
    input  logic      oe_n,
    output port_req_t req
);
    always_comb begin
        req.sel = !cs_n && cs;
        req.wr  = req.sel && !rw_n;
        req.rd  = req.sel && rw_n && !oe_n;
    end
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_l,
    input  logic              wr_l,
    input  logic              rd_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic              sel_r,
    input  logic              wr_r,
    input  logic              rd_r,
    input  logic [ADDR_W-1:0] addr_r,
    output logic              busy_l,
    output logic              busy_r
);
    typedef struct packed {
        logic              sel_l;
        logic              sel_r;
        logic [ADDR_W-1:0] addr_l;
        logic [ADDR_W-1:0] addr_r;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  coll;
    logic  hold_l, hold_r;
    logic  right_wins;

    always_comb begin
        hist_d.sel_l  = sel_l;
        hist_d.sel_r  = sel_r;
        hist_d.addr_l = addr_l;
        hist_d.addr_r = addr_r;

        coll       = sel_l && sel_r && (addr_l == addr_r) && (wr_l || wr_r);
        hold_l     = hist_q.sel_l && (hist_q.addr_l == addr_l);
        hold_r     = hist_q.sel_r && (hist_q.addr_r == addr_r);
        right_wins = hold_r && !hold_l;
        busy_l     = coll && right_wins;
        busy_r     = coll && !right_wins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    p_one_loser_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_l, busy_r}));

    p_shared_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_l && rd_r && addr_l == addr_r) |-> (!busy_l && !busy_r));
endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_l,
    input  logic              rd_l,
    input  logic              blk_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] wdata_l,
    input  logic              wr_r,
    input  logic              rd_r,
    input  logic              blk_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] wdata_r,
    output logic [DATA_W-1:0] rdata_l,
    output logic              rvalid_l,
    output logic [DATA_W-1:0] rdata_r,
    output logic              rvalid_r
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata_l;
        logic              rvalid_l;
        logic [DATA_W-1:0] rdata_r;
        logic              rvalid_r;
    } out_t;

    logic [DATA_W-1:0] mem [DEPTH];
    out_t out_d, out_q;
    logic we_l, we_r;

    always_comb begin
        we_l           = wr_l && !blk_l;
        we_r           = wr_r && !blk_r;
        out_d          = out_q;
        out_d.rvalid_l = rd_l;
        out_d.rvalid_r = rd_r;
        if (rd_l) out_d.rdata_l = mem[addr_l];
        if (rd_r) out_d.rdata_r = mem[addr_r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // Left is applied last so it prevails if both sides land unblocked.
    always_ff @(posedge clk) begin
        if (we_r) mem[addr_r] <= wdata_r;
        if (we_l) mem[addr_l] <= wdata_l;
    end

    assign rdata_l  = out_q.rdata_l;
    assign rvalid_l = out_q.rvalid_l;
    assign rdata_r  = out_q.rdata_r;
    assign rvalid_r = out_q.rvalid_r;

    p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_l |=> rvalid_l);

    p_idle_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_r |=> !rvalid_r);
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              l_cs_n,
    input  logic              l_cs,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    input  logic              r_cs_n,
    input  logic              r_cs,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    input  logic              r_busy_in,
    output logic              r_busy_out
);
    logic      cs_n_a [NUM_SIDES];
    logic      cs_a   [NUM_SIDES];
    logic      rw_n_a [NUM_SIDES];
    logic      oe_n_a [NUM_SIDES];
    port_req_t req_a  [NUM_SIDES];

    assign cs_n_a[SIDE_L] = l_cs_n;
    assign cs_n_a[SIDE_R] = r_cs_n;
    assign cs_a[SIDE_L]   = l_cs;
    assign cs_a[SIDE_R]   = r_cs;
    assign rw_n_a[SIDE_L] = l_rw_n;
    assign rw_n_a[SIDE_R] = r_rw_n;
    assign oe_n_a[SIDE_L] = l_oe_n;
    assign oe_n_a[SIDE_R] = r_oe_n;

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_dec
        dpram_port_dec dec_i (
            .cs_n (cs_n_a[s]),
            .cs   (cs_a[s]),
            .rw_n (rw_n_a[s]),
            .oe_n (oe_n_a[s]),
            .req  (req_a[s])
        );
    end

    logic arb_busy_l, arb_busy_r;
    logic blk_l, blk_r;

    dpram_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_l  (req_a[SIDE_L].sel),
        .wr_l   (req_a[SIDE_L].wr),
        .rd_l   (req_a[SIDE_L].rd),
        .addr_l (l_addr),
        .sel_r  (req_a[SIDE_R].sel),
        .wr_r   (req_a[SIDE_R].wr),
        .rd_r   (req_a[SIDE_R].rd),
        .addr_r (r_addr),
        .busy_l (arb_busy_l),
        .busy_r (arb_busy_r)
    );

    always_comb begin
        l_busy_out = master_sel && arb_busy_l;
        r_busy_out = master_sel && arb_busy_r;
        blk_l      = master_sel ? arb_busy_l : l_busy_in;
        blk_r      = master_sel ? arb_busy_r : r_busy_in;
    end

    dpram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_l     (req_a[SIDE_L].wr),
        .rd_l     (req_a[SIDE_L].rd),
        .blk_l    (blk_l),
        .addr_l   (l_addr),
        .wdata_l  (l_wdata),
        .wr_r     (req_a[SIDE_R].wr),
        .rd_r     (req_a[SIDE_R].rd),
        .blk_r    (blk_r),
        .addr_r   (r_addr),
        .wdata_r  (r_wdata),
        .rdata_l  (l_rdata),
        .rvalid_l (l_rvalid),
        .rdata_r  (r_rdata),
        .rvalid_r (r_rvalid)
    );

    p_secondary_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (!l_busy_out && !r_busy_out));

    p_collision_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && req_a[SIDE_L].sel && req_a[SIDE_R].sel && l_addr == r_addr
         && (req_a[SIDE_L].wr || req_a[SIDE_R].wr)) |-> (l_busy_out || r_busy_out));
endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic clk = 0, rst_n = 0, master_sel = 1;
    logic l_cs_n, l_cs, l_rw_n, l_oe_n, l_busy_in, l_rvalid, l_busy_out;
    logic r_cs_n, r_cs, r_rw_n, r_oe_n, r_busy_in, r_rvalid, r_busy_out;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic [DW-1:0] exp_mem [N];
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_l(input logic c0n, input logic c1, input logic rwn, input logic oen,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_cs_n = c0n; l_cs = c1; l_rw_n = rwn; l_oe_n = oen; l_addr = a; l_wdata = d;
    endtask

    task automatic set_r(input logic c0n, input logic c1, input logic rwn, input logic oen,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_cs_n = c0n; r_cs = c1; r_rw_n = rwn; r_oe_n = oen; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        set_l(1, 0, 1, 1, '0, '0);
        set_r(1, 0, 1, 1, '0, '0);
    endtask

    task automatic edge_wait();
        @(posedge clk); #1;
    endtask

    task automatic read_r(input logic [AW-1:0] a, input string req);
        @(negedge clk); idle(); set_r(0, 1, 1, 0, a, '0);
        edge_wait();
        check(req, {31'd0, r_rvalid}, 32'd1);
        check(req, {24'd0, r_rdata}, {24'd0, exp_mem[a]});
    endtask

    initial begin
        #(20 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(); l_busy_in = 0; r_busy_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R12 rvalid", {30'd0, l_rvalid, r_rvalid}, 32'd0);
        check("R12 busy", {30'd0, l_busy_out, r_busy_out}, 32'd0);

        // R2 R3: fill from left, read back from right
        for (int a = 0; a < N; a++) begin
            @(negedge clk); idle(); set_l(0, 1, 0, 0, AW'(a), DW'(a * 37 + 5));
            edge_wait(); exp_mem[a] = DW'(a * 37 + 5);
        end
        for (int a = 0; a < N; a++) read_r(AW'(a), "R3 right read");

        // R2: right writes with output enable high, left reads
        for (int a = 0; a < N; a++) begin
            @(negedge clk); idle(); set_r(0, 1, 0, 1, AW'(a), ~DW'(a * 11));
            edge_wait(); exp_mem[a] = ~DW'(a * 11);
        end
        for (int a = 0; a < N; a++) begin
            @(negedge clk); idle(); set_l(0, 1, 1, 0, AW'(a), '0);
            edge_wait();
            check("R2 left read", {24'd0, l_rdata}, {24'd0, exp_mem[a]});
        end

        // R1: enable combinations on writes and reads
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); idle(); set_l(c[1], c[0], 0, 0, 3, DW'(8'h80 + c));
            edge_wait();
            if (c == 1) exp_mem[3] = DW'(8'h80 + c);
            read_r(3, "R1 write select");
            @(negedge clk); idle(); set_l(c[1], c[0], 1, 0, 3, '0);
            edge_wait();
            check("R1 read select", {31'd0, l_rvalid}, {31'd0, c == 1});
        end

        // R4: output enable high, and a write, give no valid
        @(negedge clk); idle(); set_l(0, 1, 1, 1, 2, '0);
        edge_wait();
        check("R4 oe high", {31'd0, l_rvalid}, 32'd0);
        @(negedge clk); idle(); set_r(0, 1, 0, 0, 2, 8'h3C);
        edge_wait(); exp_mem[2] = 8'h3C;
        check("R4 write no valid", {31'd0, r_rvalid}, 32'd0);

        // R5: shared reads of every location
        for (int a = 0; a < N; a++) begin
            @(negedge clk); set_l(0, 1, 1, 0, AW'(a), '0); set_r(0, 1, 1, 0, AW'(a), '0);
            #1;
            check("R5 no busy", {30'd0, l_busy_out, r_busy_out}, 32'd0);
            edge_wait();
            check("R5 both data", {l_rdata, r_rdata}, {exp_mem[a], exp_mem[a]});
        end

        // R6 R7: left write vs right read, every address pair
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                @(negedge clk); set_l(0, 1, 0, 1, AW'(i), DW'(i * j + 1)); set_r(0, 1, 1, 0, AW'(j), '0);
                #1;
                check("R6 busy pair", {30'd0, l_busy_out, r_busy_out}, {30'd0, 1'b0, i == j});
                edge_wait(); exp_mem[i] = DW'(i * j + 1);
            end
        end

        // R7 R9: fresh tie, both write
        @(negedge clk); idle(); edge_wait();
        @(negedge clk); set_l(0, 1, 0, 0, 6, 8'h11); set_r(0, 1, 0, 0, 6, 8'h22);
        #1;
        check("R7 tie left wins", {30'd0, l_busy_out, r_busy_out}, 32'd1);
        edge_wait(); exp_mem[6] = 8'h11;
        read_r(6, "R9 right write dropped");

        // R8 R9: right holds address 5
        @(negedge clk); idle(); set_r(0, 1, 1, 0, 5, '0);
        edge_wait();
        @(negedge clk); set_l(0, 1, 0, 0, 5, 8'h5A);
        #1;
        check("R8 holder keeps", {30'd0, l_busy_out, r_busy_out}, 32'd2);
        edge_wait();
        read_r(5, "R9 left write dropped");

        // R10: secondary role
        master_sel = 0;
        @(negedge clk); idle(); edge_wait();
        @(negedge clk); l_busy_in = 1; r_busy_in = 0;
        set_l(0, 1, 0, 0, 7, 8'h44); set_r(0, 1, 0, 0, 7, 8'h33);
        #1;
        check("R10 busy outs low", {30'd0, l_busy_out, r_busy_out}, 32'd0);
        edge_wait(); exp_mem[7] = 8'h33;
        read_r(7, "R10 busy input blocks");
        @(negedge clk); idle(); r_busy_in = 1; set_r(0, 1, 0, 0, 9, 8'h77);
        edge_wait();
        read_r(9, "R10 right busy input blocks");

        // R11: primary role ignores busy inputs
        master_sel = 1;
        @(negedge clk); idle(); l_busy_in = 1; set_l(0, 1, 0, 0, 8, 8'h99);
        edge_wait(); exp_mem[8] = 8'h99;
        read_r(8, "R11 inputs ignored");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule